// File: doc/BRIEF.md
# One-Wire Bus Master

This block drives a single open-drain one-wire line as the bus master. It accepts one bit-level operation at a time on a valid/ready command port. The four operations are a write slot carrying a one, a write slot carrying a zero, a read slot, and a reset with presence detection. It controls the line only through `drive_low_o`: when asserted, the external pin pulls the line to ground, and otherwise the pin lets an external resistor pull the line high. The block observes the line on `line_i`. Every interval is a parameter in microseconds. A prescaler of `CLK_PER_US` system clocks turns each interval into cycles and restarts when a command is accepted, so each slot has exact cycle timing.

Command back-pressure works as follows. `cmd_ready_o` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. While an operation runs, `cmd_valid_i` and `cmd_op_i` are ignored, so the requester holds its command until ready returns. When an operation finishes, `done_o` pulses for one clock. At that point the result outputs `rd_bit_o`, `presence_o` and `fault_o` are valid. They keep their values until the next command is accepted.

A read slot decides its bit by when the line recovers, measured against a deadline, rather than by a single mid-slot sample. A reset checks that the line idles high both before and after the pulse, and reports a line that is held low as a fault.

Top module: `ow_master`

## Requirements
- R1: `cmd_ready_o` is high only when idle, and the line is never pulled low while it is high. A command is accepted on an edge where valid and ready are both high. `cmd_valid_i`/`cmd_op_i` have no effect while busy. The opcode encoding is 0 = write zero, 1 = write one, 2 = read, 3 = reset.
- R2: Let k count clock cycles after the accepting edge, starting at k = 0. An interval boundary at N µs falls at k = N·CLK_PER_US.
- R3: A write-one slot pulls the line low for k < T_LOW1·CLK_PER_US, then releases it. `done_o` is high exactly at k = (T_SLOT+T_REC)·CLK_PER_US.
- R4: A write-zero slot pulls the line low for k < T_LOW0·CLK_PER_US, then releases it. It finishes at the same point as R3.
- R5: A read slot pulls the line low for k < T_LOWR·CLK_PER_US, then releases it. `rd_bit_o` is 1 if and only if the synchronized line is seen high at some k with T_LOWR·CLK_PER_US ≤ k < T_RDV·CLK_PER_US. The slot finishes as in R3.
- R6: `line_i` passes through two flip-flops before any decision. A decision made in cycle c uses the `line_i` value of cycle c−2.
- R7: A reset that is accepted while the synchronized line is low does not pull the line low. It finishes at k = 0 with `fault_o`=1 and `presence_o`=0.
- R8: Otherwise, a reset pulls the line low for k < T_RSTL·CLK_PER_US. It samples the synchronized line in cycle k = (T_RSTL+T_PDH+T_PDL/2)·CLK_PER_US − 1, and `presence_o` is 1 if that sample is low.
- R9: The reset samples the synchronized line again in cycle (T_RSTL+T_RSTH)·CLK_PER_US − 1. If that sample is low, `fault_o`=1 and `presence_o`=0. `done_o` rises at k = (T_RSTL+T_RSTH)·CLK_PER_US. Presence and fault are never both set.
- R10: `done_o` lasts exactly one cycle. The three results are cleared at acceptance (visible at k = 0, except in the R7 case) and hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 2 | Operation code (see R1) |
| cmd_ready_o | output | 1 | Block idle, command will be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rd_bit_o | output | 1 | Bit returned by the last read slot |
| presence_o | output | 1 | A device answered the last reset |
| fault_o | output | 1 | Line found held low during the last reset |
| drive_low_o | output | 1 | Pull the line low when high, release when low |
| line_i | input | 1 | Line level as seen at the pin |

## Verification
Write slots are issued with the requester still holding valid and changing the opcode while the block is busy. This separates correct back-pressure from a block that restarts or changes its slot timing. Read slots are run against a device that releases the line at several points: at once, just before the deadline, at the deadline, and well after it. These tell apart a deadline that is off by one cycle or ignores the synchronizer delay from one that is correct. Reset is tried with a device that answers, with an empty bus, with a line held low after the presence window, and with a line already held low at acceptance. Together these cover presence, both fault paths, and the rule that presence and fault exclude each other.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_WR0   = 2'd0,
    OP_WR1   = 2'd1,
    OP_READ  = 2'd2,
    OP_RESET = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2,
    ST_DONE = 2'd3
  } ow_state_e;

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      stab_q <= meta_q;
    end
  end

  assign line_s_o = stab_q;
endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
  parameter int CLK_PER_US = 250,
  parameter int UW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic          tick_o,
  output logic [UW-1:0] us_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;

  assign tick_o = (pre_q == PRE_LAST);
  assign us_o   = us_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick_o) begin
      pre_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R2: each tick advances the microsecond count by exactly one
  p_tick_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clr_i) |=> (us_o == $past(us_o) + 1'b1));
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_pkg::*;
#(
  parameter int UW     = 11,
  parameter int T_RSTL = 480,
  parameter int T_RSTH = 480,
  parameter int T_PDH  = 15,
  parameter int T_PDL  = 60,
  parameter int T_SLOT = 60,
  parameter int T_LOW1 = 6,
  parameter int T_LOW0 = 60,
  parameter int T_LOWR = 6,
  parameter int T_RDV  = 15,
  parameter int T_REC  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  ow_op_e        cmd_op_i,
  input  logic          line_s_i,
  input  logic          tick_i,
  input  logic [UW-1:0] us_i,
  output logic          tmr_clr_o,
  output logic          cmd_ready_o,
  output logic          drive_low_o,
  output logic          done_o,
  output logic          rd_bit_o,
  output logic          presence_o,
  output logic          fault_o
);
  localparam logic [UW-1:0] SLOT_END_M1 = UW'(T_SLOT + T_REC - 1);
  localparam logic [UW-1:0] RST_END_M1  = UW'(T_RSTL + T_RSTH - 1);
  localparam logic [UW-1:0] PRES_M1     = UW'(T_RSTL + T_PDH + T_PDL / 2 - 1);
  localparam logic [UW-1:0] RDV_U       = UW'(T_RDV);
  localparam logic [UW-1:0] WATCH_M1    = UW'(T_RDV + 1);

  ow_state_e     state_q;
  ow_op_e        op_q;
  logic          watch_q, rd_q, pres_q, flt_q;
  logic [UW-1:0] low_m1, end_m1;
  logic          is_reset;

  always_comb begin
    case (op_q)
      OP_WR1:  low_m1 = UW'(T_LOW1 - 1);
      OP_WR0:  low_m1 = UW'(T_LOW0 - 1);
      OP_READ: low_m1 = UW'(T_LOWR - 1);
      default: low_m1 = UW'(T_RSTL - 1);
    endcase
  end

  assign is_reset    = (op_q == OP_RESET);
  assign end_m1      = is_reset ? RST_END_M1 : SLOT_END_M1;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign tmr_clr_o   = (state_q == ST_IDLE);
  assign drive_low_o = (state_q == ST_LOW);
  assign done_o      = (state_q == ST_DONE);
  assign rd_bit_o    = rd_q;
  assign presence_o  = pres_q;
  assign fault_o     = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_WR0;
      watch_q <= 1'b0;
      rd_q    <= 1'b0;
      pres_q  <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_q    <= cmd_op_i;
          watch_q <= 1'b1;
          rd_q    <= 1'b0;
          pres_q  <= 1'b0;
          if (cmd_op_i == OP_RESET && !line_s_i) begin
            flt_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            flt_q   <= 1'b0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: if (tick_i && us_i == low_m1) state_q <= ST_REL;
        ST_REL: begin
          if (op_q == OP_READ && watch_q) begin
            if (line_s_i) begin
              watch_q <= 1'b0;
              if (us_i < RDV_U) rd_q <= 1'b1;
            end else if (tick_i && us_i == WATCH_M1) begin
              watch_q <= 1'b0;
            end
          end
          if (is_reset && tick_i && us_i == PRES_M1) pres_q <= !line_s_i;
          if (tick_i && us_i == end_m1) begin
            state_q <= ST_DONE;
            if (is_reset && !line_s_i) begin
              flt_q  <= 1'b1;
              pres_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: an idle block never holds the line low
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !drive_low_o);
  // R3: an accepted slot or healthy reset starts by pulling the line low
  p_accept_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && cmd_valid_i && !(cmd_op_i == OP_RESET && !line_s_i)) |=> drive_low_o);
  // R7: a reset on a low line finishes at once with a fault and no drive
  p_precheck_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && cmd_valid_i && cmd_op_i == OP_RESET && !line_s_i)
      |=> (done_o && fault_o && !drive_low_o));
  // R9: presence and fault never reported together
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(presence_o && fault_o));
  // R10: completion pulse lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: results hold while idle and nothing is accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && !cmd_valid_i) |=> ($stable(rd_bit_o) && $stable(presence_o) && $stable(fault_o)));
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int T_RSTL     = 480,
  parameter int T_RSTH     = 480,
  parameter int T_PDH      = 15,
  parameter int T_PDL      = 60,
  parameter int T_SLOT     = 60,
  parameter int T_LOW1     = 6,
  parameter int T_LOW0     = 60,
  parameter int T_LOWR     = 6,
  parameter int T_RDV      = 15,
  parameter int T_REC      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  output logic       cmd_ready_o,
  output logic       done_o,
  output logic       rd_bit_o,
  output logic       presence_o,
  output logic       fault_o,
  output logic       drive_low_o,
  input  logic       line_i
);
  localparam int MAX_US = ((T_RSTL + T_RSTH) > (T_SLOT + T_REC)) ?
                          (T_RSTL + T_RSTH) : (T_SLOT + T_REC);
  localparam int UW = $clog2(MAX_US + 2) + 1;

  logic          line_s, tick, tmr_clr;
  logic [UW-1:0] us;

  ow_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_s_o(line_s)
  );

  ow_us_timer #(.CLK_PER_US(CLK_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_o(tick), .us_o(us)
  );

  ow_slot_fsm #(
    .UW(UW), .T_RSTL(T_RSTL), .T_RSTH(T_RSTH), .T_PDH(T_PDH), .T_PDL(T_PDL),
    .T_SLOT(T_SLOT), .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_LOWR(T_LOWR),
    .T_RDV(T_RDV), .T_REC(T_REC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(ow_op_e'(cmd_op_i)),
    .line_s_i(line_s), .tick_i(tick), .us_i(us),
    .tmr_clr_o(tmr_clr), .cmd_ready_o(cmd_ready_o), .drive_low_o(drive_low_o),
    .done_o(done_o), .rd_bit_o(rd_bit_o), .presence_o(presence_o), .fault_o(fault_o)
  );
endmodule

// File: tb/ow_master_tb_top.sv
module ow_master_tb_top;
  localparam int P = 2;
  localparam int RSTL = 480, RSTH = 480, PDH = 15, PDL = 60, SLOT = 60;
  localparam int LOW1 = 6, LOW0 = 60, LOWR = 6, RDV = 15, REC = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0, slave_pull = 1'b0, stuck = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, done, rd_bit, presence, fault, drive_low, line;

  assign line = !(drive_low || slave_pull || stuck);

  ow_master #(.CLK_PER_US(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ready_o(cmd_ready), .done_o(done), .rd_bit_o(rd_bit),
    .presence_o(presence), .fault_o(fault), .drive_low_o(drive_low), .line_i(line)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  bit hist [65536];

  task automatic step(input bit pull);
    @(negedge clk);
    slave_pull = pull;
    #1;
    hist[cyc & 16'hFFFF] = line;
    cyc++;
  endtask

  function automatic bit hs(input int c);
    return hist[c & 16'hFFFF];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one command; the device pulls low for lo <= k < hi.
  task automatic run(input int op, input int lo, input int hi, input bit hold);
    int a, lowc, endk, pres_k;
    bit exp_bit, exp_pres, exp_flt;
    step(0);
    a = cyc - 1;
    chk("R1", "ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    exp_bit = 0; exp_pres = 0; exp_flt = 0;
    pres_k = (RSTL + PDH + PDL / 2) * P - 1;
    if (op == 3 && !hs(a - 2)) begin
      lowc = 0; endk = 0; exp_flt = 1;
    end else if (op == 3) begin
      lowc = RSTL * P; endk = (RSTL + RSTH) * P;
    end else begin
      lowc = (op == 1 ? LOW1 : op == 0 ? LOW0 : LOWR) * P;
      endk = (SLOT + REC) * P;
    end
    for (int k = 0; k <= endk; k++) begin
      step(k >= lo && k < hi);
      if (hold && k < endk - 2) begin
        cmd_valid = 1'b1;
        cmd_op = 2'(op ^ 1);
      end else begin
        cmd_valid = 1'b0;
      end
      chk(op == 1 ? "R3" : op == 0 ? "R4" : op == 2 ? "R5" : "R8", "drive_low",
          int'(drive_low), int'(k < lowc));
      chk("R2", "done timing", int'(done), int'(k == endk));
      chk("R1", "ready while busy", int'(cmd_ready), 0);
      if (k == 0 && endk != 0)
        chk("R10", "results cleared", int'({rd_bit, presence, fault}), 0);
      if (op == 2 && k >= lowc && k < RDV * P && hs(a + k - 1)) exp_bit = 1;
      if (k == endk) begin
        if (op == 3 && endk != 0) begin
          exp_flt  = !hs(a + 1 + endk - 3);
          exp_pres = !hs(a + 1 + pres_k - 2) && !exp_flt;
        end
        chk("R5", "rd_bit", int'(rd_bit), int'(exp_bit));
        chk(endk == 0 ? "R7" : "R8", "presence", int'(presence), int'(exp_pres));
        chk(endk == 0 ? "R7" : "R9", "fault", int'(fault), int'(exp_flt));
      end
    end
    step(0);
    chk("R1", "ready after done", int'(cmd_ready), 1);
    chk("R10", "done one cycle", int'(done), 0);
    chk("R10", "results held", int'({rd_bit, presence, fault}),
        int'({exp_bit, exp_pres, exp_flt}));
  endtask

  initial begin
    repeat (3) step(0);
    rst_n = 1'b1;
    step(0);
    chk("R1", "reset ready", int'(cmd_ready), 1);
    chk("R10", "reset outputs", int'({done, rd_bit, presence, fault, drive_low}), 0);
    // write slots, one with valid held and opcode changing while busy (R1)
    run(1, 0, 0, 0);
    run(0, 0, 0, 0);
    run(1, 0, 0, 1);
    // read slots (R5, R6): release points around the deadline
    run(2, 0, 0, 0);
    run(2, 0, RDV * P - 3, 0);
    run(2, 0, RDV * P - 2, 0);
    run(2, 0, 60 * P, 0);
    run(2, 0, 200 * P, 0);
    // resets: device answers, empty bus, line stuck after window (R8, R9)
    run(3, (RSTL + 20) * P, (RSTL + 120) * P, 0);
    run(3, 0, 0, 0);
    run(3, (RSTL + 20) * P, 1 << 30, 0);
    // line low before reset (R7)
    stuck = 1'b1;
    repeat (4) step(0);
    run(3, 0, 0, 0);
    stuck = 1'b0;
    repeat (4) step(0);
    run(3, (RSTL + 20) * P, (RSTL + 120) * P, 0);
    run(0, 0, 0, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule